// File: doc/BRIEF.md
# Burst Sync Word Detector

This block recovers bit timing from a filtered 1152 kbit/s serial receive stream and flags the slot synchronization word. A digital phase tracker samples the input at twelve times the bit rate and keeps a phase counter. It moves this counter one step whenever an input transition arrives early or late. Once per bit period, at mid-bit, it emits the recovered bit together with a one-cycle enable.

Each enable shifts the recovered bit into a 20-bit history register. A correlator compares the 16 most recent bits with the expected sync word and tolerates a programmable number of mismatching bits. A match counts only while an external bit counter lies inside a programmable window. The four older bits are checked against the tail of the preamble, so a word that fits the sync pattern but lacks a correct preamble tail can be told apart. Such a word may come from an interferer that slides across the slot. A polarity input inverts the incoming data, so that one build serves both ends of the link.

Top module: `burst_sync_detector`

## Requirements
- R1: The phase counter runs through OSR states (default 12). Every time it reaches OSR/2, the input is sampled, and one cycle later rec_bit_o shows the sample while rec_bit_en_o is high for exactly one cycle.
- R2: A transition seen at phase 0 changes nothing. A transition seen at phase 1 to OSR/2-1 holds the counter for one cycle. A transition seen at phase OSR/2 to OSR-1 makes the counter skip one value. As a result, bits lasting OSR-1 or OSR+1 cycles are still recovered in order, with none lost or repeated.
- R3: On each enable, the recovered bit enters bit 0 of the 20-bit history, and every older bit moves up one place. Without an enable, the history holds its value.
- R4: A word is accepted when the number of positions in which history bits 15:0 differ from the sync word 16'hE98A is no greater than err_limit_i. The first-received bit of the word sits in bit 15. A limit of 0 demands an exact match.
- R5: A word is accepted only if win_open_i <= bit_count_i <= win_close_i holds, with both bounds inclusive. The inputs are sampled two clock cycles after the enable of the word's last bit.
- R6: lock_ok_o pulses together with slot_sync_o exactly when history bits 19:16 equal 4'b1010 (bit 19 received first). It is never high without slot_sync_o.
- R7: When polarity_flip_i is 1, the received data is inverted before bit recovery. The complementary waveform therefore yields the same recovered bits and the same detection.
- R8: slot_sync_o is a one-cycle pulse. It rises three clock cycles after the rec_bit_en_o pulse of the bit that completes the word.
- R9: While rst_n is low, all outputs are 0. The phase counter and the history are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 12x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit_i | input | 1 | Filtered serial receive data |
| polarity_flip_i | input | 1 | 1 inverts the incoming data |
| err_limit_i | input | 5 | Largest tolerated number of mismatching bits |
| bit_count_i | input | CNT_W (9) | External bit position within the slot |
| win_open_i | input | CNT_W (9) | First bit count at which detection is allowed |
| win_close_i | input | CNT_W (9) | Last bit count at which detection is allowed |
| rec_bit_o | output | 1 | Recovered data bit |
| rec_bit_en_o | output | 1 | One-cycle strobe marking a new recovered bit |
| slot_sync_o | output | 1 | Sync word accepted |
| lock_ok_o | output | 1 | Accepted word preceded by a correct preamble tail |

## Verification
The bench builds the block with its defaults: OSR 12, a 9-bit bit counter and the 16-bit word with a 4-bit tail. Every bit index of a slot of a few hundred bits therefore lands inside the counter range. The exact-bound window cases (open equal to close, and one past either end) can be hit on the very bit that completes a word. At OSR 12, stretching or shrinking a bit by one cycle moves a transition to phase 1 or phase 11. This exercises both correction directions while the mid-bit sample keeps a margin of five cycles. The 5-bit limit reaches the range from exact match up to several tolerated errors, and one corrupted word is presented at limits on both sides of its error count.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int SYNC_W = 16;
  localparam int TAIL_W = 4;
  localparam int REG_W  = SYNC_W + TAIL_W;
  localparam int ERR_W  = $clog2(SYNC_W + 1);

  typedef logic [SYNC_W-1:0] sync_word_t;
  typedef logic [TAIL_W-1:0] tail_t;
  typedef logic [REG_W-1:0]  bit_hist_t;
  typedef logic [ERR_W-1:0]  err_cnt_t;

  // Number of bit positions in which two words differ.
  function automatic err_cnt_t mismatch_count(input sync_word_t seen, input sync_word_t want);
    err_cnt_t   n;
    sync_word_t d;
    n = '0;
    d = seen ^ want;
    for (int i = 0; i < SYNC_W; i++) n = n + err_cnt_t'(d[i]);
    return n;
  endfunction

  // Next phase: +1 normally, +0 on a late transition, +2 on an early one.
  function automatic int phase_next(input int ph, input logic trans, input int osr);
    int step;
    if (!trans || ph == 0) step = 1;
    else if (ph < osr / 2) step = 0;
    else                   step = 2;
    return (ph + step) % osr;
  endfunction
endpackage

// File: rtl/bsd_dpll.sv
module bsd_dpll
  import bsd_pkg::*;
#(
  parameter int OSR  = 12,
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din_i,
  input  logic            flip_i,
  output logic            bit_o,
  output logic            en_o,
  output logic [PH_W-1:0] phase_o,
  output logic            trans_o
);
  localparam int MID = OSR / 2;

  logic            in_q;
  logic            prev_q;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;

  assign trans_o = in_q ^ prev_q;
  assign phase_o = phase_q;

  always_comb phase_d = PH_W'(phase_next(int'(phase_q), trans_o, OSR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      prev_q  <= 1'b0;
      phase_q <= '0;
      bit_o   <= 1'b0;
      en_o    <= 1'b0;
    end else begin
      in_q    <= din_i ^ flip_i;
      prev_q  <= in_q;
      phase_q <= phase_d;
      if (phase_q == PH_W'(MID)) begin
        bit_o <= in_q;
        en_o  <= 1'b1;
      end else begin
        en_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bsd_history.sv
module bsd_history
  import bsd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_i,
  input  logic      en_i,
  output bit_hist_t hist_o,
  output logic      fresh_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_o  <= '0;
      fresh_o <= 1'b0;
    end else begin
      fresh_o <= en_i;
      if (en_i) hist_o <= {hist_o[REG_W-2:0], bit_i};
    end
  end
endmodule

// File: rtl/bsd_correlator.sv
module bsd_correlator
  import bsd_pkg::*;
#(
  parameter int         CNT_W = 9,
  parameter sync_word_t WORD  = 16'hE98A,
  parameter tail_t      TAIL  = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bit_hist_t        hist_i,
  input  logic             fresh_i,
  input  logic [CNT_W-1:0] bit_count_i,
  input  logic [CNT_W-1:0] win_open_i,
  input  logic [CNT_W-1:0] win_close_i,
  input  err_cnt_t         err_limit_i,
  output err_cnt_t         err_o,
  output logic             slot_sync_o,
  output logic             lock_o
);
  logic eval_q;
  logic win_q;
  logic tail_q;
  logic accept_w;

  assign accept_w = eval_q && win_q && (err_o <= err_limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_q      <= 1'b0;
      win_q       <= 1'b0;
      tail_q      <= 1'b0;
      err_o       <= '0;
      slot_sync_o <= 1'b0;
      lock_o      <= 1'b0;
    end else begin
      eval_q      <= fresh_i;
      err_o       <= mismatch_count(hist_i[SYNC_W-1:0], WORD);
      win_q       <= (bit_count_i >= win_open_i) && (bit_count_i <= win_close_i);
      tail_q      <= (hist_i[REG_W-1:SYNC_W] == TAIL);
      slot_sync_o <= accept_w;
      lock_o      <= accept_w && tail_q;
    end
  end
endmodule

// File: rtl/burst_sync_detector.sv
module burst_sync_detector
  import bsd_pkg::*;
#(
  parameter int         OSR       = 12,
  parameter int         CNT_W     = 9,
  parameter sync_word_t SYNC_WORD = 16'hE98A,
  parameter tail_t      TAIL_WORD = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit_i,
  input  logic             polarity_flip_i,
  input  logic [ERR_W-1:0] err_limit_i,
  input  logic [CNT_W-1:0] bit_count_i,
  input  logic [CNT_W-1:0] win_open_i,
  input  logic [CNT_W-1:0] win_close_i,
  output logic             rec_bit_o,
  output logic             rec_bit_en_o,
  output logic             slot_sync_o,
  output logic             lock_ok_o
);
  localparam int PH_W = $clog2(OSR);

  // Internal events brought out for the checker.
  logic [PH_W-1:0] phase_w;
  logic            trans_w;
  bit_hist_t       hist_w;
  logic            fresh_w;
  err_cnt_t        err_w;

  bsd_dpll #(.OSR(OSR), .PH_W(PH_W)) u_dpll (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (rx_bit_i),
    .flip_i (polarity_flip_i),
    .bit_o  (rec_bit_o),
    .en_o   (rec_bit_en_o),
    .phase_o(phase_w),
    .trans_o(trans_w)
  );

  bsd_history u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_i  (rec_bit_o),
    .en_i   (rec_bit_en_o),
    .hist_o (hist_w),
    .fresh_o(fresh_w)
  );

  bsd_correlator #(.CNT_W(CNT_W), .WORD(SYNC_WORD), .TAIL(TAIL_WORD)) u_corr (
    .clk        (clk),
    .rst_n      (rst_n),
    .hist_i     (hist_w),
    .fresh_i    (fresh_w),
    .bit_count_i(bit_count_i),
    .win_open_i (win_open_i),
    .win_close_i(win_close_i),
    .err_limit_i(err_limit_i),
    .err_o      (err_w),
    .slot_sync_o(slot_sync_o),
    .lock_o     (lock_ok_o)
  );
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker
  import bsd_pkg::*;
#(
  parameter int OSR   = 12,
  parameter int CNT_W = 9,
  parameter int PH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rec_bit_o,
  input logic             rec_bit_en_o,
  input logic             slot_sync_o,
  input logic             lock_ok_o,
  input logic [PH_W-1:0]  phase_w,
  input logic             trans_w,
  input bit_hist_t        hist_w,
  input logic [CNT_W-1:0] bit_count_i,
  input logic [CNT_W-1:0] win_open_i,
  input logic [CNT_W-1:0] win_close_i
);
  logic win_ok;
  assign win_ok = (bit_count_i >= win_open_i) && (bit_count_i <= win_close_i);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, phase_w} < (PH_W+1)'(OSR)); // R1
  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_bit_en_o |=> !rec_bit_en_o); // R1
  AST_LATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_w && phase_w != '0 && {1'b0, phase_w} < (PH_W+1)'(OSR/2)) |=> $stable(phase_w)); // R2
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    rec_bit_en_o |=> (hist_w[0] == $past(rec_bit_o))); // R3
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_bit_en_o |=> $stable(hist_w)); // R3
  AST_SYNC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    slot_sync_o |-> $past(win_ok, 2)); // R5
  AST_LOCK_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok_o |-> slot_sync_o); // R6
  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_sync_o |=> !slot_sync_o); // R8
  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    slot_sync_o |-> $past(rec_bit_en_o, 3)); // R8
endmodule

bind burst_sync_detector bsd_checker #(.OSR(OSR), .CNT_W(CNT_W), .PH_W(PH_W)) u_bsd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rec_bit_o   (rec_bit_o),
  .rec_bit_en_o(rec_bit_en_o),
  .slot_sync_o (slot_sync_o),
  .lock_ok_o   (lock_ok_o),
  .phase_w     (phase_w),
  .trans_w     (trans_w),
  .hist_w      (hist_w),
  .bit_count_i (bit_count_i),
  .win_open_i  (win_open_i),
  .win_close_i (win_close_i)
);

// File: tb/burst_sync_detector_tb_top.sv
module burst_sync_detector_tb_top;
  localparam int OSR   = 12;
  localparam int CNT_W = 9;
  localparam int ERR_W = 5;
  localparam logic [15:0] WORD = 16'hE98A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             rx_bit = 1'b0;
  logic             flip = 1'b0;
  logic [ERR_W-1:0] lim = '0;
  logic [CNT_W-1:0] bcnt = '0;
  logic [CNT_W-1:0] wopen = '0;
  logic [CNT_W-1:0] wclose = '1;
  logic rec_bit_o, rec_bit_en_o, slot_sync_o, lock_ok_o;

  burst_sync_detector dut_i (
    .clk(clk), .rst_n(rst_n), .rx_bit_i(rx_bit), .polarity_flip_i(flip),
    .err_limit_i(lim), .bit_count_i(bcnt), .win_open_i(wopen), .win_close_i(wclose),
    .rec_bit_o(rec_bit_o), .rec_bit_en_o(rec_bit_en_o),
    .slot_sync_o(slot_sync_o), .lock_ok_o(lock_ok_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Scoreboard: {bit, expected sync, expected lock} and the requirement tag.
  logic [2:0] sb_q[$];
  string      tag_q[$];
  logic [19:0] model_hist = '0;
  int          bit_idx = 0;
  string       seg_tag = "R1";
  logic [15:0] seed = 16'hACE1;

  task automatic send_bit(input logic b, input int len = OSR);
    logic [15:0] diff;
    int errs;
    logic es, el;
    model_hist = {model_hist[18:0], b};
    diff = model_hist[15:0] ^ WORD;
    errs = 0;
    for (int i = 0; i < 16; i++) if (diff[i]) errs++;
    es = (errs <= int'(lim)) && (bit_idx >= int'(wopen)) && (bit_idx <= int'(wclose));
    el = es && (model_hist[19:16] == 4'b1010);
    sb_q.push_back({b, es, el});
    tag_q.push_back(seg_tag);
    bcnt   = CNT_W'(bit_idx);
    rx_bit = b ^ flip;
    repeat (len) @(negedge clk);
    bit_idx++;
  endtask

  task automatic send_filler(input int n);
    for (int i = 0; i < n; i++) begin
      seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
      send_bit(seed[0]);
    end
  endtask

  task automatic send_word(input logic [3:0] tail, input logic [15:0] w);
    for (int i = 3; i >= 0; i--) send_bit(tail[i]);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  // Monitor: pops one item per strobe, checks the sync outputs three cycles on.
  logic [2:0] p0 = '0, p1 = '0, p2 = '0;
  bit v0 = 0, v1 = 0, v2 = 0;
  string t0 = "", t1 = "", t2 = "";
  logic [2:0] item;
  string tg;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (v2) begin
        checks++;
        if (slot_sync_o !== p2[1] || lock_ok_o !== p2[0]) begin
          fails++;
          $display("FAIL %s/R4/R5/R6/R8 sync=%b lock=%b expected sync=%b lock=%b",
                   t2, slot_sync_o, lock_ok_o, p2[1], p2[0]);
        end
      end else if (slot_sync_o !== 1'b0 || lock_ok_o !== 1'b0) begin
        checks++;
        fails++;
        $display("FAIL R8 stray pulse sync=%b lock=%b expected sync=0 lock=0", slot_sync_o, lock_ok_o);
      end
      v2 = v1; p2 = p1; t2 = t1;
      v1 = v0; p1 = p0; t1 = t0;
      v0 = 1'b0;
      if (rec_bit_en_o) begin
        checks++;
        if (sb_q.size() == 0) begin
          fails++;
          $display("FAIL R1 strobe with no bit sent: actual en=1 expected en=0");
        end else begin
          item = sb_q.pop_front();
          tg   = tag_q.pop_front();
          if (rec_bit_o !== item[2]) begin
            fails++;
            $display("FAIL %s/R1/R3 bit %0d: actual %b expected %b", tg, checks, rec_bit_o, item[2]);
          end
          v0 = 1'b1; p0 = item; t0 = tg;
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (slot_sync_o !== 1'b0 || lock_ok_o !== 1'b0 || rec_bit_en_o !== 1'b0 || rec_bit_o !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset outputs=%b%b%b%b expected 0000", slot_sync_o, lock_ok_o, rec_bit_en_o, rec_bit_o);
    end
    rst_n = 1'b1;
    // R4/R6: exact word with correct tail
    seg_tag = "R4";
    send_filler(6);
    send_word(4'b1010, WORD);
    // R4: two corrupted bits, limit above and below
    lim = 5'd2; send_filler(4); send_word(4'b1010, WORD ^ 16'h0204);
    lim = 5'd1; send_filler(4); send_word(4'b1010, WORD ^ 16'h0204);
    lim = 5'd0;
    // R6: good word, bad preamble tail
    seg_tag = "R6";
    send_filler(4); send_word(4'b1011, WORD);
    // R5: window bounds
    seg_tag = "R5";
    send_filler(4); wopen = CNT_W'(bit_idx + 19); wclose = CNT_W'(bit_idx + 19); send_word(4'b1010, WORD);
    send_filler(4); wopen = CNT_W'(bit_idx + 20); wclose = '1; send_word(4'b1010, WORD);
    send_filler(4); wopen = '0; wclose = CNT_W'(bit_idx + 18); send_word(4'b1010, WORD);
    wopen = '0; wclose = '1;
    // R7: inverted line polarity
    seg_tag = "R7";
    flip = 1'b1;
    send_filler(4); send_word(4'b1010, WORD);
    send_filler(2);
    flip = 1'b0;
    // R2: bits shortened and stretched by one cycle
    seg_tag = "R2";
    wopen = '1; wclose = '0;
    for (int i = 0; i < 40; i++) begin
      if (i % 4 == 1)      send_bit(logic'(i % 2), OSR - 1);
      else if (i % 4 == 3) send_bit(logic'(i % 2), OSR + 1);
      else                 send_bit(logic'(i % 2));
    end
    seg_tag = "R1";
    send_filler(6);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule